// File: doc/BRIEF.md
# Serial Port Register and Interrupt Front End

This block is the bus-facing register file of a simple serial port that has no FIFOs. A 32-bit word-addressed bus reads and writes five registers: a data register (received byte on read, byte to send on write), an interrupt enable register, an interrupt identification register, a line status register and a modem status register. A deserializer hands over received bytes through a valid strobe. The block keeps them in a one-byte holding register and raises an overrun flag when a byte arrives before the previous one was read. A serializer takes bytes through a one-cycle strobe.

A single interrupt line is raised whenever an enabled source is active. The identification register names the most urgent source, using a fixed four-level order: line errors, then received data, then transmit holding empty, then modem status. Illegal accesses (partial byte enables, unknown offsets, writes to read-only registers) pulse an error output and have no other effect.

Register offsets (word units): 0 data, 1 interrupt enable, 2 identification, 3 line status, 4 modem status; offsets 5 to 7 are unknown.

Top module: `serial_port_regs`

## Requirements
- R1: After reset the line status register reads 0x60 (bit 5 transmit-holding-empty and bit 6 transmitter-empty set), interrupt enable reads 0, data reads 0, identification reads 0x01, `irq` is low and `rx_ready` is high.
- R2: Identification codes follow a fixed priority: a line error (line status bits 1 overrun, 2 parity, 3 framing or 4 break) with enable bit 2 gives 0x06; otherwise data-ready (line status bit 0) with enable bit 0 gives 0x04; otherwise transmit-holding-empty with enable bit 1 gives 0x02; otherwise a modem source with enable bit 3 gives 0x00.
- R3: When no enabled source is active the identification register reads 0x01 and `irq` is low; otherwise `irq` is high. `irq` reflects the register state from the cycle after the event that changed it.
- R4: The modem status register holds `modem_in` as sampled one cycle earlier; its low four bits form the modem interrupt source.
- R5: A data register read returns the held byte in bits 7:0 and clears data-ready; `rx_ready` equals the inverse of data-ready.
- R6: A byte arriving while data-ready is set and not being cleared by a data read in the same cycle sets overrun (bit 1); the new byte replaces the held one and data-ready stays set.
- R7: A legal write to the data register produces `tx_valid` high for one cycle with `tx_byte` equal to write data bits 7:0, in the cycle after the request.
- R8: The parity, framing and break flags of an arriving byte set line status bits 2, 3 and 4; a line status read returns the flags and then clears bits 1 to 4; a new flag arriving in the same cycle wins over the clear.
- R9: `bus_err` pulses in the cycle after a request whose byte enables are not all set, whose offset is 5 to 7, or that writes offset 2, 3 or 4; such a request changes no register and sends no byte.
- R10: The interrupt enable register stores write data bits 3:0 and reads them back with zero upper bits.
- R11: `bus_rdata` carries the read value in the cycle after the read request and is zero after any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset |
| bus_be | input | BUS_W/8 | Byte enables; all must be set |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, cycle after request |
| bus_err | output | 1 | Illegal access pulse, cycle after request |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | CHAR_W | Received byte |
| rx_parity_err | input | 1 | Parity error flag of the byte |
| rx_frame_err | input | 1 | Framing error flag of the byte |
| rx_break | input | 1 | Break condition flag of the byte |
| rx_ready | output | 1 | Holding register is free |
| tx_valid | output | 1 | Transmit strobe |
| tx_byte | output | CHAR_W | Byte to transmit |
| modem_in | input | 8 | Modem status bits |
| irq | output | 1 | Interrupt request |

## Verification
The priority encoder is swept over all sixteen enable values crossed with every combination of the line-error, data-ready and modem sources, with transmit-empty always present. This separates a wrong order between any pair of levels from a missing enable gate. Directed sequences of single, back-to-back and read-interleaved byte arrivals distinguish overrun set, replace-on-overrun and read-clear behaviour. An access sweep over every offset, direction and partial byte-enable pattern separates legal accesses from the three illegal kinds and shows that illegal writes leave state untouched.

// File: rtl/sp_regs_pkg.sv
// Package: shared constants for the serial port register front end.
// Holds register offsets, line status and enable bit positions, and
// the identification codes. Assumes word-addressed 32-bit accesses.
package sp_regs_pkg;
    localparam int OFF_DATA = 0;
    localparam int OFF_IEN  = 1;
    localparam int OFF_IID  = 2;
    localparam int OFF_LSR  = 3;
    localparam int OFF_MSR  = 4;
    localparam int OFF_LAST = 4;

    localparam int LSR_DR   = 0;
    localparam int LSR_OE   = 1;
    localparam int LSR_PE   = 2;
    localparam int LSR_FE   = 3;
    localparam int LSR_BI   = 4;
    localparam int LSR_THRE = 5;
    localparam int LSR_TEMT = 6;

    localparam int IEN_RXD  = 0;
    localparam int IEN_THR  = 1;
    localparam int IEN_LINE = 2;
    localparam int IEN_MDM  = 3;
    localparam int IEN_W    = 4;

    localparam logic [2:0] IID_NONE  = 3'b001;
    localparam logic [2:0] IID_LINE  = 3'b110;
    localparam logic [2:0] IID_RXD   = 3'b100;
    localparam logic [2:0] IID_THR   = 3'b010;
    localparam logic [2:0] IID_MODEM = 3'b000;

    typedef struct packed {
        logic bi;
        logic fe;
        logic pe;
        logic oe;
        logic dr;
    } rx_stat_t;
endpackage

// File: rtl/sp_bus_decode.sv
// Module: bus access decoder.
// Classifies each request as legal or illegal and produces one-hot
// action strobes for the register file. Assumes one-cycle requests;
// illegal requests raise a registered error pulse and no action strobe.
module sp_bus_decode #(
    parameter int ADDR_W = 3,
    parameter int BE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BE_W-1:0]   be,
    output logic              wr_data,
    output logic              wr_ien,
    output logic              rd_ok,
    output logic              rd_data,
    output logic              rd_lsr,
    output logic              err_q
);
    import sp_regs_pkg::*;

    logic full_word;
    logic known_off;
    logic read_only;
    logic illegal;
    logic legal;

    // Classify the current request.
    always_comb begin
        full_word = (be == {BE_W{1'b1}});
        known_off = (int'(addr) <= OFF_LAST);
        read_only = (int'(addr) == OFF_IID) || (int'(addr) == OFF_LSR) ||
                    (int'(addr) == OFF_MSR);
        illegal   = req && (!full_word || !known_off || (we && read_only));
        legal     = req && !illegal;
    end

    // Action strobes for legal requests.
    always_comb begin
        wr_data = legal && we  && (int'(addr) == OFF_DATA);
        wr_ien  = legal && we  && (int'(addr) == OFF_IEN);
        rd_ok   = legal && !we;
        rd_data = rd_ok && (int'(addr) == OFF_DATA);
        rd_lsr  = rd_ok && (int'(addr) == OFF_LSR);
    end

    // Registered error pulse, one cycle after an illegal request.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= illegal;
    end

    assert_err_on_partial_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (be != {BE_W{1'b1}})) |=> err_q);

    assert_no_action_when_bad_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !known_off) |-> !(wr_data || wr_ien || rd_ok));
endmodule

// File: rtl/sp_rx_hold.sv
// Module: receive holding register and line status flags.
// Keeps one received byte, the data-ready flag and the sticky overrun,
// parity, framing and break flags. Assumes an arrival outranks a clear
// requested in the same cycle.
module sp_rx_hold #(
    parameter int CHAR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_valid,
    input  logic [CHAR_W-1:0]     rx_byte,
    input  logic                  rx_parity_err,
    input  logic                  rx_frame_err,
    input  logic                  rx_break,
    input  logic                  clr_data,
    input  logic                  clr_line,
    output logic [CHAR_W-1:0]     held_q,
    output sp_regs_pkg::rx_stat_t stat_q
);
    import sp_regs_pkg::*;

    logic overrun_now;

    // Overrun when a byte lands on an unread byte not being read now.
    always_comb overrun_now = rx_valid && stat_q.dr && !clr_data;

    // Byte storage: latest arrival replaces the held byte.
    always_ff @(posedge clk) begin
        if (!rst_n)        held_q <= '0;
        else if (rx_valid) held_q <= rx_byte;
    end

    // Data-ready: set by arrival, cleared by data read.
    always_ff @(posedge clk) begin
        if (!rst_n)        stat_q.dr <= 1'b0;
        else if (rx_valid) stat_q.dr <= 1'b1;
        else if (clr_data) stat_q.dr <= 1'b0;
    end

    // Sticky error flags: set on arrival, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q.oe <= 1'b0;
            stat_q.pe <= 1'b0;
            stat_q.fe <= 1'b0;
            stat_q.bi <= 1'b0;
        end else begin
            if (overrun_now)                 stat_q.oe <= 1'b1;
            else if (clr_line)               stat_q.oe <= 1'b0;
            if (rx_valid && rx_parity_err)   stat_q.pe <= 1'b1;
            else if (clr_line)               stat_q.pe <= 1'b0;
            if (rx_valid && rx_frame_err)    stat_q.fe <= 1'b1;
            else if (clr_line)               stat_q.fe <= 1'b0;
            if (rx_valid && rx_break)        stat_q.bi <= 1'b1;
            else if (clr_line)               stat_q.bi <= 1'b0;
        end
    end

    assert_overrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && stat_q.dr && !clr_data) |=> (stat_q.oe && stat_q.dr));

    assert_read_clears_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_data && !rx_valid) |=> !stat_q.dr);

    assert_status_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_line && !rx_valid) |=> !(stat_q.oe || stat_q.pe || stat_q.fe || stat_q.bi));
endmodule

// File: rtl/sp_irq_prio.sv
// Module: fixed-priority interrupt identification.
// Picks the most urgent enabled source and produces its code and the
// pending flag. Purely combinational; assumes registered inputs.
module sp_irq_prio (
    input  logic [sp_regs_pkg::IEN_W-1:0] ien,
    input  logic                          line_err,
    input  logic                          data_ready,
    input  logic                          thr_empty,
    input  logic                          modem_act,
    output logic [2:0]                    iid,
    output logic                          pending
);
    import sp_regs_pkg::*;

    logic [3:0] active;

    // Gate each source with its enable bit.
    always_comb begin
        active[0] = line_err   && ien[IEN_LINE];
        active[1] = data_ready && ien[IEN_RXD];
        active[2] = thr_empty  && ien[IEN_THR];
        active[3] = modem_act  && ien[IEN_MDM];
    end

    // Encode the highest-ranked active source.
    always_comb begin
        if (active[0])      iid = IID_LINE;
        else if (active[1]) iid = IID_RXD;
        else if (active[2]) iid = IID_THR;
        else if (active[3]) iid = IID_MODEM;
        else                iid = IID_NONE;
        pending = |active;
    end
endmodule

// File: rtl/serial_port_regs.sv
// Module: serial port register and interrupt front end (top).
// Maps data, enable, identification, line status and modem status
// registers onto a word-addressed bus, holds one received byte, strobes
// bytes to a serializer and drives one interrupt line. Assumes the
// transmitter accepts every strobe at once, so its empty flags stay set.
module serial_port_regs #(
    parameter int ADDR_W = 3,
    parameter int BUS_W  = 32,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W/8-1:0] bus_be,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              bus_err,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_byte,
    input  logic              rx_parity_err,
    input  logic              rx_frame_err,
    input  logic              rx_break,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_byte,
    input  logic [7:0]        modem_in,
    output logic              irq
);
    import sp_regs_pkg::*;

    localparam int BE_W  = BUS_W / 8;
    localparam int LSR_W = 8;

    logic             wr_data, wr_ien, rd_ok, rd_data, rd_lsr;
    logic [IEN_W-1:0] ien_q;
    logic [7:0]       msr_q;
    logic [CHAR_W-1:0] held_q;
    rx_stat_t         stat_q;
    logic [LSR_W-1:0] lsr_val;
    logic [2:0]       iid;
    logic             pending;
    logic [BUS_W-1:0] rd_mux;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata[BUS_W-1:CHAR_W];

    sp_bus_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) dec_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (bus_req),
        .we      (bus_we),
        .addr    (bus_addr),
        .be      (bus_be),
        .wr_data (wr_data),
        .wr_ien  (wr_ien),
        .rd_ok   (rd_ok),
        .rd_data (rd_data),
        .rd_lsr  (rd_lsr),
        .err_q   (bus_err)
    );

    sp_rx_hold #(.CHAR_W(CHAR_W)) rx_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_valid      (rx_valid),
        .rx_byte       (rx_byte),
        .rx_parity_err (rx_parity_err),
        .rx_frame_err  (rx_frame_err),
        .rx_break      (rx_break),
        .clr_data      (rd_data),
        .clr_line      (rd_lsr),
        .held_q        (held_q),
        .stat_q        (stat_q)
    );

    // Assemble the line status value; transmitter flags are always set.
    always_comb begin
        lsr_val           = '0;
        lsr_val[LSR_DR]   = stat_q.dr;
        lsr_val[LSR_OE]   = stat_q.oe;
        lsr_val[LSR_PE]   = stat_q.pe;
        lsr_val[LSR_FE]   = stat_q.fe;
        lsr_val[LSR_BI]   = stat_q.bi;
        lsr_val[LSR_THRE] = 1'b1;
        lsr_val[LSR_TEMT] = 1'b1;
    end

    sp_irq_prio prio_i (
        .ien        (ien_q),
        .line_err   (stat_q.oe | stat_q.pe | stat_q.fe | stat_q.bi),
        .data_ready (stat_q.dr),
        .thr_empty  (lsr_val[LSR_THRE]),
        .modem_act  (|msr_q[3:0]),
        .iid        (iid),
        .pending    (pending)
    );

    assign irq      = pending;
    assign rx_ready = !stat_q.dr;

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (wr_ien) ien_q <= bus_wdata[IEN_W-1:0];
    end

    // Modem status register samples its input every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) msr_q <= '0;
        else        msr_q <= modem_in;
    end

    // Transmit strobe and byte, one cycle after a data write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= wr_data;
            if (wr_data) tx_byte <= bus_wdata[CHAR_W-1:0];
        end
    end

    // Read multiplexer over the register offsets.
    always_comb begin
        rd_mux = '0;
        case (int'(bus_addr))
            OFF_DATA: rd_mux[CHAR_W-1:0] = held_q;
            OFF_IEN:  rd_mux[IEN_W-1:0]  = ien_q;
            OFF_IID:  rd_mux[2:0]        = iid;
            OFF_LSR:  rd_mux[LSR_W-1:0]  = lsr_val;
            OFF_MSR:  rd_mux[7:0]        = msr_q;
            default:  rd_mux             = '0;
        endcase
    end

    // Registered read data, zero when no legal read was made.
    always_ff @(posedge clk) begin
        if (!rst_n)     bus_rdata <= '0;
        else if (rd_ok) bus_rdata <= rd_mux;
        else            bus_rdata <= '0;
    end

    assert_tx_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> (tx_valid && tx_byte == $past(bus_wdata[CHAR_W-1:0])));

    assert_idle_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (iid == IID_NONE));

    assert_line_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q.oe || stat_q.pe) && ien_q[IEN_LINE]) |-> (irq && iid == IID_LINE));

    assert_ready_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid) |=> !rx_ready);
endmodule

// File: tb/serial_port_regs_tb_top.sv
// Bench: sweeps priority encoding, receive paths and bus legality.
module serial_port_regs_tb_top;
    localparam int AW = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_parity_err = 1'b0, rx_frame_err = 1'b0, rx_break = 1'b0;
    logic        rx_ready, tx_valid, irq;
    logic [7:0]  tx_byte;
    logic [7:0]  modem_in = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] rd;
    logic        er, tv;
    logic [7:0]  tb;

    always #4 clk = ~clk;

    serial_port_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_parity_err(rx_parity_err),
        .rx_frame_err(rx_frame_err), .rx_break(rx_break), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .modem_in(modem_in), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One bus access; outputs sampled at the negedge after the active edge.
    task automatic access(input logic we, input int addr, input logic [31:0] wd,
                          input logic [3:0] be);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = AW'(addr);
        bus_wdata = wd; bus_be = be;
        @(negedge clk);
        rd = bus_rdata; er = bus_err; tv = tx_valid; tb = tx_byte;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic push(input logic [7:0] b, input logic pe, input logic fe, input logic bk);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        rx_parity_err = pe; rx_frame_err = fe; rx_break = bk;
        @(negedge clk);
        rx_valid = 1'b0; rx_parity_err = 1'b0; rx_frame_err = 1'b0; rx_break = 1'b0;
    endtask

    function automatic logic [2:0] exp_iid(input logic [3:0] en, input bit le,
                                           input bit dr, input bit md);
        if (le && en[2])      return 3'd6;
        else if (dr && en[0]) return 3'd4;
        else if (en[1])       return 3'd2;
        else if (md && en[3]) return 3'd0;
        else                  return 3'd1;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", 32'(irq), 0);
        check("R1 rx_ready", 32'(rx_ready), 1);
        access(0, 3, 0, 4'hF); check("R1 lsr", rd, 32'h60);
        access(0, 1, 0, 4'hF); check("R1 ien", rd, 0);
        access(0, 0, 0, 4'hF); check("R1 data", rd, 0);
        access(0, 2, 0, 4'hF); check("R1 iid", rd, 32'h01);
        // R11 read data returns to zero after a non-read cycle
        @(negedge clk); check("R11 rdata idle", bus_rdata, 0);

        // R10 enable register keeps the low four bits
        access(1, 1, 32'hFFFF_FFF5, 4'hF); check("R10 no err", 32'(er), 0);
        access(0, 1, 0, 4'hF); check("R10 ien readback", rd, 32'h5);
        access(1, 1, 0, 4'hF);

        // R7 transmit strobe
        access(1, 0, 32'h1234_56A7, 4'hF);
        check("R7 tx_valid", 32'(tv), 1);
        check("R7 tx_byte", 32'(tb), 32'hA7);
        @(negedge clk); check("R7 single pulse", 32'(tx_valid), 0);

        // R5 receive and read-clear
        push(8'h3C, 0, 0, 0);
        check("R5 rx_ready low", 32'(rx_ready), 0);
        access(0, 3, 0, 4'hF); check("R5 lsr dr", rd, 32'h61);
        access(0, 0, 0, 4'hF); check("R5 data", rd, 32'h3C);
        check("R5 rx_ready high", 32'(rx_ready), 1);
        access(0, 3, 0, 4'hF); check("R5 lsr cleared", rd, 32'h60);

        // R6 overrun: second byte replaces first
        push(8'h11, 0, 0, 0);
        push(8'h22, 0, 0, 0);
        access(0, 3, 0, 4'hF); check("R6 lsr overrun", rd, 32'h63);
        access(0, 3, 0, 4'hF); check("R8 overrun cleared", rd, 32'h61);
        access(0, 0, 0, 4'hF); check("R6 newest byte", rd, 32'h22);
        // R6 arrival in the same cycle as a data read: no overrun
        push(8'h33, 0, 0, 0);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 0; bus_be = 4'hF;
        rx_valid = 1'b1; rx_byte = 8'h44;
        @(negedge clk);
        check("R6 read with arrival data", bus_rdata, 32'h33);
        bus_req = 1'b0; rx_valid = 1'b0;
        access(0, 3, 0, 4'hF); check("R6 no overrun on read", rd, 32'h61);
        access(0, 0, 0, 4'hF); check("R6 arrival kept", rd, 32'h44);

        // R8 error flags per position
        push(8'h01, 1, 0, 0); access(0, 3, 0, 4'hF); check("R8 parity", rd, 32'h65);
        access(0, 0, 0, 4'hF);
        push(8'h02, 0, 1, 0); access(0, 3, 0, 4'hF); check("R8 framing", rd, 32'h69);
        access(0, 0, 0, 4'hF);
        push(8'h03, 0, 0, 1); access(0, 3, 0, 4'hF); check("R8 break", rd, 32'h71);
        access(0, 0, 0, 4'hF);
        access(0, 3, 0, 4'hF); check("R8 all cleared", rd, 32'h60);

        // R4 modem register sampling
        @(negedge clk); modem_in = 8'hA5;
        @(negedge clk);
        access(0, 4, 0, 4'hF); check("R4 msr", rd, 32'hA5);
        modem_in = 8'h00;

        // R2/R3 priority sweep: all enables x line/ready/modem sources
        for (int en = 0; en < 16; en++) begin
            for (int p = 0; p < 8; p++) begin
                bit le, dr, md;
                le = p[0]; dr = p[1]; md = p[2];
                access(1, 1, 0, 4'hF);
                access(0, 0, 0, 4'hF);
                access(0, 3, 0, 4'hF);
                @(negedge clk); modem_in = md ? 8'h08 : 8'h00;
                if (le) begin push(8'h5A, 1, 0, 0); access(0, 0, 0, 4'hF); end
                if (dr) push(8'hA5, 0, 0, 0);
                access(1, 1, 32'(en), 4'hF);
                check($sformatf("R3 irq en=%0d p=%0d", en, p), 32'(irq),
                      32'(exp_iid(4'(en), le, dr, md) != 3'd1));
                access(0, 2, 0, 4'hF);
                check($sformatf("R2 iid en=%0d p=%0d", en, p), rd,
                      32'(exp_iid(4'(en), le, dr, md)));
            end
        end
        modem_in = 8'h00;
        access(1, 1, 0, 4'hF);
        access(0, 0, 0, 4'hF);
        access(0, 3, 0, 4'hF);

        // R9 access legality sweep
        access(1, 1, 32'h3, 4'hF);
        for (int a = 0; a < 8; a++) begin
            for (int w = 0; w < 2; w++) begin
                for (int b = 0; b < 16; b++) begin
                    bit bad;
                    bad = (b != 15) || (a > 4) || (w == 1 && a >= 2);
                    access(w[0], a, 32'hFFFF_FFFF, 4'(b));
                    check($sformatf("R9 err a=%0d w=%0d be=%0h", a, w, b), 32'(er), 32'(bad));
                    if (w == 1) check($sformatf("R9 tx a=%0d be=%0h", a, b), 32'(tv),
                                      32'(!bad && a == 0));
                    if (w == 1 && a == 1 && !bad) access(1, 1, 32'h3, 4'hF);
                end
            end
        end
        access(0, 1, 0, 4'hF); check("R9 ien untouched", rd, 32'h3);
        access(0, 3, 0, 4'hF); check("R9 lsr untouched", rd, 32'h60);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule